// File: doc/BRIEF.md
# Dead-Time PWM Timer with Conversion Strobe

This block is a 12-bit up-counting timer that drives a complementary pair of power-switch outputs and one strobe that triggers an analog-to-digital conversion. A divider produces the timer clock, one timer step every one to eight input clocks. A byte-wide register port holds three 12-bit values and one 5-bit dead-time value. The 12-bit values are a first compare point, a second compare point and the period. When the first compare point is reached, switch output one turns on, and switch output two follows after the dead time. At the period boundary, output two turns off first and output one follows after the same dead time. The strobe goes high at the second compare point and can issue a one-cycle conversion request.

Compare and period writes made while the timer runs are held in software-visible registers. They take effect only at the next counter wrap, so every PWM cycle runs with one consistent set of values. In capture mode the second switch pin becomes an input. The counter then runs freely over its full range. A selected edge on that pin copies the counter into the period register and sets a sticky flag. The register port is a plain single-cycle write strobe with a combinational read. Every write completes in its cycle, so there is no back-pressure to handle.

Top module: `dtpwm_timer`

## Requirements
- R1: After reset the low bytes read 0xFF, the high bytes read 0x0F, the dead-time register reads 0x1F and the status register reads 0x00. Register addresses: 0/1 compare A low/high, 2/3 compare B low/high, 4/5 period low/high, 6 dead time, 7 status. While the timer is disabled, all three switch-side outputs are low, `count_o` is 0 and `hs2_oe` is 1.
- R2: A read returns the last value written, including the capture result. A high byte keeps only its low 4 bits, and the upper nibble reads as zero.
- R3: While enabled, the counter advances once every `psel`+1 input clocks. The first step occurs on the (`psel`+1)-th clock edge after enable is set.
- R4: In PWM mode, a timer step taken at the period value returns the counter to 0.
- R5: In PWM mode, `hs1_o` rises on the step at compare A. `hs2_o` rises D steps later, where D is the dead time, or on the same step when D = 0.
- R6: In PWM mode, `hs2_o` falls on the step at the period value. `hs1_o` falls D steps later, or on the same step when D = 0.
- R7: `strobe_o` rises on the step at compare B and falls on the wrap step. When `adc_en` is set, `adc_req` is high for exactly the one input clock that follows the rising step.
- R8: A write to a compare value while running is readable at once. It changes the outputs only from the cycle that starts after the next wrap.
- R9: A write to the dead-time register while enabled is ignored. The read back value and the waveform both stay unchanged.
- R10: Clearing `enable` forces `hs1_o`, `hs2_o`, `strobe_o` and `adc_req` low and the counter to 0 on the next clock edge.
- R11: In capture mode, `hs2_oe` and `hs2_o` are 0. An edge of `cap_in` (rising when `cap_fall`=0, falling when `cap_fall`=1) stores `count_o` into the period register and sets status bit 0. The value stored is the one held during the third input clock after the pin change. An edge of the other polarity stores nothing.
- R12: Writing 1 to status bit 0 clears the capture flag. Writing 0 leaves it set.
- R13: In capture mode the counter runs through 0xFFF and then to 0. `hs1_o` rises at compare A and falls on the wrap step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Run the timer |
| cap_mode | input | 1 | 1 selects capture mode |
| cap_fall | input | 1 | Capture edge: 0 rising, 1 falling |
| adc_en | input | 1 | Enable conversion requests |
| psel | input | 3 | Timer clock divide minus one |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for `addr` |
| cap_in | input | 1 | Capture pin input |
| hs1_o | output | 1 | Switch output one |
| hs2_o | output | 1 | Switch output two |
| hs2_oe | output | 1 | Drive enable for switch pin two |
| strobe_o | output | 1 | Conversion strobe |
| adc_req | output | 1 | One-cycle conversion request |
| count_o | output | 12 | Current counter value |

## Verification
The ordering assertions assume that software keeps the PWM values consistent. Compare A plus the dead time stays below the period, the dead time does not exceed compare A, and compare B stays below the period. They also assume that the mode and divide select change only while the timer is disabled. The bench sweeps every divide ratio over several small settings that respect these limits, and also one 12-bit setting with the largest dead time. Run-time writes are placed in the middle of a cycle, never on a wrap step. Capture pulses are applied with the counter stepping every clock, so the latched value can be predicted exactly.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;
  localparam int ADR_W = 3;
  localparam int BYTE_W = 8;
  localparam logic [ADR_W-1:0] ADR_A_LO = 3'd0;
  localparam logic [ADR_W-1:0] ADR_A_HI = 3'd1;
  localparam logic [ADR_W-1:0] ADR_B_LO = 3'd2;
  localparam logic [ADR_W-1:0] ADR_B_HI = 3'd3;
  localparam logic [ADR_W-1:0] ADR_P_LO = 3'd4;
  localparam logic [ADR_W-1:0] ADR_P_HI = 3'd5;
  localparam logic [ADR_W-1:0] ADR_DEAD = 3'd6;
  localparam logic [ADR_W-1:0] ADR_STAT = 3'd7;

  typedef enum logic [1:0] {
    DT_IDLE,
    DT_RISE,
    DT_FALL
  } dt_phase_t;
endpackage

// File: rtl/dtpwm_prescaler.sv
module dtpwm_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  logic [PS_W-1:0] div_q;

  assign tick = run && (div_q == sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!run || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/dtpwm_regs.sv
module dtpwm_regs
  import dtpwm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic             wrap,
  input  logic             cap_load,
  input  logic [CNT_W-1:0] cap_value,
  output logic [CNT_W-1:0] act_a,
  output logic [CNT_W-1:0] act_b,
  output logic [CNT_W-1:0] act_p,
  output logic [DT_W-1:0]  dead
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [CNT_W-1:0] soft_a, soft_b, soft_p;
  logic             flag;

  function automatic logic [CNT_W-1:0] put_byte(input logic [CNT_W-1:0] old,
                                                input logic hi,
                                                input logic [BYTE_W-1:0] d);
    logic [CNT_W-1:0] r;
    r = old;
    if (hi) r[CNT_W-1:BYTE_W] = d[HI_W-1:0];
    else    r[BYTE_W-1:0]     = d;
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] get_byte(input logic [CNT_W-1:0] v,
                                                 input logic hi);
    logic [BYTE_W-1:0] r;
    r = '0;
    if (hi) r[HI_W-1:0] = v[CNT_W-1:BYTE_W];
    else    r           = v[BYTE_W-1:0];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_a <= '1;
      soft_b <= '1;
      soft_p <= '1;
      dead   <= '1;
      flag   <= 1'b0;
    end else begin
      if (wr_en) begin
        unique case (addr)
          ADR_A_LO, ADR_A_HI: soft_a <= put_byte(soft_a, addr[0], wdata);
          ADR_B_LO, ADR_B_HI: soft_b <= put_byte(soft_b, addr[0], wdata);
          ADR_P_LO, ADR_P_HI: soft_p <= put_byte(soft_p, addr[0], wdata);
          ADR_DEAD: if (!run) dead <= wdata[DT_W-1:0];
          ADR_STAT: if (wdata[0]) flag <= 1'b0;
          default: ;
        endcase
      end
      if (cap_load) begin
        soft_p <= cap_value;
        flag   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a <= '1;
      act_b <= '1;
      act_p <= '1;
    end else if (!run || wrap) begin
      act_a <= soft_a;
      act_b <= soft_b;
      act_p <= soft_p;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADR_A_LO, ADR_A_HI: rdata = get_byte(soft_a, addr[0]);
      ADR_B_LO, ADR_B_HI: rdata = get_byte(soft_b, addr[0]);
      ADR_P_LO, ADR_P_HI: rdata = get_byte(soft_p, addr[0]);
      ADR_DEAD: rdata[DT_W-1:0] = dead;
      ADR_STAT: rdata[0] = flag;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dtpwm_capture.sv
module dtpwm_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_hit
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign edge_hit = fall_sel ? (s3 & ~s2) : (s2 & ~s3);
endmodule

// File: rtl/dtpwm_core.sv
module dtpwm_core
  import dtpwm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cap_mode,
  input  logic             adc_en,
  input  logic             tick,
  input  logic             cap_edge,
  input  logic [CNT_W-1:0] act_a,
  input  logic [CNT_W-1:0] act_b,
  input  logic [CNT_W-1:0] act_p,
  input  logic [DT_W-1:0]  dead,
  output logic             hs1,
  output logic             hs2,
  output logic             hs2_oe,
  output logic             strobe,
  output logic             adc_req,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             cap_load,
  output logic [CNT_W-1:0] cap_value
);
  logic [CNT_W-1:0] limit;
  logic             at_lim, at_a, at_b, dead_zero;
  dt_phase_t        phase;
  logic [DT_W-1:0]  dt_cnt;

  assign limit     = cap_mode ? {CNT_W{1'b1}} : act_p;
  assign at_lim    = (count == limit);
  assign at_a      = (count == act_a);
  assign at_b      = (count == act_b);
  assign dead_zero = (dead == '0);
  assign wrap      = tick && at_lim;
  assign hs2_oe    = !cap_mode;
  assign cap_load  = run && cap_mode && cap_edge;
  assign cap_value = count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      hs1     <= 1'b0;
      hs2     <= 1'b0;
      strobe  <= 1'b0;
      adc_req <= 1'b0;
      phase   <= DT_IDLE;
      dt_cnt  <= '0;
    end else if (!run) begin
      count   <= '0;
      hs1     <= 1'b0;
      hs2     <= 1'b0;
      strobe  <= 1'b0;
      adc_req <= 1'b0;
      phase   <= DT_IDLE;
      dt_cnt  <= '0;
    end else begin
      adc_req <= 1'b0;
      if (tick) begin
        count <= at_lim ? '0 : count + 1'b1;

        if (at_lim) begin
          strobe <= 1'b0;
        end else if (at_b) begin
          strobe  <= 1'b1;
          adc_req <= adc_en;
        end

        if (cap_mode) begin
          hs2   <= 1'b0;
          phase <= DT_IDLE;
          if (at_lim)    hs1 <= 1'b0;
          else if (at_a) hs1 <= 1'b1;
        end else begin
          unique case (phase)
            DT_RISE: begin
              if (dt_cnt == dead) begin
                hs2   <= 1'b1;
                phase <= DT_IDLE;
              end else begin
                dt_cnt <= dt_cnt + 1'b1;
              end
            end
            DT_FALL: begin
              if (dt_cnt == dead) begin
                hs1   <= 1'b0;
                phase <= DT_IDLE;
              end else begin
                dt_cnt <= dt_cnt + 1'b1;
              end
            end
            default: ;
          endcase

          if (at_a && !at_lim) begin
            hs1 <= 1'b1;
            if (dead_zero) begin
              hs2 <= 1'b1;
            end else begin
              phase  <= DT_RISE;
              dt_cnt <= {{(DT_W-1){1'b0}}, 1'b1};
            end
          end

          if (at_lim) begin
            hs2 <= 1'b0;
            if (dead_zero) begin
              hs1 <= 1'b0;
            end else begin
              phase  <= DT_FALL;
              dt_cnt <= {{(DT_W-1){1'b0}}, 1'b1};
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dtpwm_timer.sv
module dtpwm_timer
  import dtpwm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DT_W  = 5,
  parameter int PS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cap_mode,
  input  logic              cap_fall,
  input  logic              adc_en,
  input  logic [PS_W-1:0]   psel,
  input  logic              wr_en,
  input  logic [ADR_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              cap_in,
  output logic              hs1_o,
  output logic              hs2_o,
  output logic              hs2_oe,
  output logic              strobe_o,
  output logic              adc_req,
  output logic [CNT_W-1:0]  count_o
);
  logic             tick, wrap, cap_edge, cap_load;
  logic [CNT_W-1:0] act_a, act_b, act_p, cap_value;
  logic [DT_W-1:0]  dead_val;

  dtpwm_prescaler #(.PS_W(PS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(enable), .sel(psel), .tick(tick)
  );

  dtpwm_regs #(.CNT_W(CNT_W), .DT_W(DT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .run(enable), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wrap(wrap), .cap_load(cap_load),
    .cap_value(cap_value), .act_a(act_a), .act_b(act_b), .act_p(act_p),
    .dead(dead_val)
  );

  dtpwm_capture u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_in), .fall_sel(cap_fall),
    .edge_hit(cap_edge)
  );

  dtpwm_core #(.CNT_W(CNT_W), .DT_W(DT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(enable), .cap_mode(cap_mode),
    .adc_en(adc_en), .tick(tick), .cap_edge(cap_edge), .act_a(act_a),
    .act_b(act_b), .act_p(act_p), .dead(dead_val), .hs1(hs1_o),
    .hs2(hs2_o), .hs2_oe(hs2_oe), .strobe(strobe_o), .adc_req(adc_req),
    .count(count_o), .wrap(wrap), .cap_load(cap_load),
    .cap_value(cap_value)
  );
endmodule

// File: rtl/dtpwm_checker.sv
module dtpwm_checker #(
  parameter int CNT_W = 12,
  parameter int DT_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             cap_mode,
  input logic             adc_en,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic             hs1_o,
  input logic             hs2_o,
  input logic             strobe_o,
  input logic             adc_req,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] act_p,
  input logic [DT_W-1:0]  dead_val
);
  a_r5_hs2_rises_under_hs1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cap_mode && $rose(hs2_o)) |-> hs1_o);

  a_r6_hs1_falls_after_hs2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cap_mode && $fell(hs1_o)) |-> !hs2_o);

  a_r7_req_inside_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |-> (strobe_o && $past(adc_en)));

  a_r7_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req |=> !adc_req);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hs1_o && !hs2_o && !strobe_o && !adc_req && count_o == '0));

  a_r4_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cap_mode) |-> (count_o <= act_p));

  a_r9_dead_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wr_en && addr == 3'd6) |=> $stable(dead_val));
endmodule

bind dtpwm_timer dtpwm_checker #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cap_mode(cap_mode),
  .adc_en(adc_en), .wr_en(wr_en), .addr(addr), .hs1_o(hs1_o),
  .hs2_o(hs2_o), .strobe_o(strobe_o), .adc_req(adc_req),
  .count_o(count_o), .act_p(act_p), .dead_val(dead_val)
);

// File: tb/dtpwm_timer_test.sv
module dtpwm_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, cap_mode = 1'b0, cap_fall = 1'b0, adc_en = 1'b0;
  logic [2:0] psel = 3'd0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       cap_in = 1'b0;
  logic       hs1_o, hs2_o, hs2_oe, strobe_o, adc_req;
  logic [11:0] count_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dtpwm_timer uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cap_mode(cap_mode),
    .cap_fall(cap_fall), .adc_en(adc_en), .psel(psel), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cap_in(cap_in),
    .hs1_o(hs1_o), .hs2_o(hs2_o), .hs2_oe(hs2_oe), .strobe_o(strobe_o),
    .adc_req(adc_req), .count_o(count_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = 3'(a); #1; d = int'(rdata);
  endtask

  task automatic set12(input int lo, input int v);
    wr(lo, v & 255);
    wr(lo + 1, v >> 8);
  endtask

  task automatic run_pwm(input int p, input int A, input int B, input int P,
                         input int D, input int adc, input int shadow,
                         input int A2, input int B2);
    int len, w1, rv;
    enable = 1'b0; cap_mode = 1'b0;
    @(negedge clk);
    set12(0, A); set12(2, B); set12(4, P); wr(6, D);
    psel = 3'(p); adc_en = adc[0];
    len = 3 * (P + 1) * (p + 1) + 2;
    w1 = ((P + 1) + 6) * (p + 1) + 1;
    enable = 1'b1;
    for (int e = 1; e <= len; e++) begin
      int n, v, cyc, ac, bc, h1, h2, st, rq, ce;
      @(posedge clk); @(negedge clk);
      n = e / (p + 1);
      h1 = 0; h2 = 0; st = 0; rq = 0; ce = n % (P + 1);
      if (n > 0) begin
        v = (n - 1) % (P + 1);
        cyc = (n - 1) / (P + 1);
        ac = (shadow != 0 && cyc * (P + 1) * (p + 1) > w1) ? A2 : A;
        bc = (shadow != 0 && cyc * (P + 1) * (p + 1) > w1 + 1) ? B2 : B;
        h1 = ((v >= ac && !(D == 0 && v == P)) || (cyc > 0 && D > 0 && v < D - 1)) ? 1 : 0;
        h2 = (v >= ac + D && v != P) ? 1 : 0;
        st = (v >= bc && v != P) ? 1 : 0;
        rq = (adc != 0 && (e % (p + 1)) == 0 && v == bc) ? 1 : 0;
      end
      check("R3/R4 count", int'(count_o), ce);
      check("R5/R6/R8 hs1", int'(hs1_o), h1);
      check("R5/R6/R8 hs2", int'(hs2_o), h2);
      check("R7/R8 strobe", int'(strobe_o), st);
      check("R7 adc_req", int'(adc_req), rq);
      if (shadow != 0) begin
        if (e == w1 - 1) begin wr_en = 1'b1; addr = 3'd0; wdata = 8'(A2); end
        if (e == w1) begin
          check("R2/R8 readback A while old in use", int'(rdata), A2);
          addr = 3'd2; wdata = 8'(B2);
        end
        if (e == w1 + 1) begin addr = 3'd6; wdata = 8'(D + 3); end
        if (e == w1 + 2) begin
          wr_en = 1'b0;
          check("R9 dead write ignored while running", int'(rdata), D);
        end
      end
    end
    if (shadow != 0) begin
      rd(2, rv); check("R8 readback B", rv, B2);
      rd(6, rv); check("R9 dead readback after run", rv, D);
    end
    enable = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10 hs1 idle", int'(hs1_o), 0);
    check("R10 hs2 idle", int'(hs2_o), 0);
    check("R10 strobe idle", int'(strobe_o), 0);
    check("R10 count idle", int'(count_o), 0);
  endtask

  task automatic capture_pulse(input logic lvl, output int expv, output int got);
    int lo, hi;
    cap_in = lvl;
    @(posedge clk); @(posedge clk); @(negedge clk);
    expv = int'(count_o);
    @(posedge clk); @(negedge clk);
    rd(4, lo); rd(5, hi);
    got = lo + (hi << 8);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rv, ex, got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, rv);
      check("R1 reset readback", rv, (a == 7) ? 0 : (a == 6) ? 31 : (a % 2 == 1) ? 15 : 255);
    end
    check("R1 hs1 reset", int'(hs1_o), 0);
    check("R1 hs2 reset", int'(hs2_o), 0);
    check("R1 strobe reset", int'(strobe_o), 0);
    check("R1 count reset", int'(count_o), 0);
    check("R1 hs2_oe reset", int'(hs2_oe), 1);
    // R2 high byte keeps four bits
    wr(1, 8'hAB); rd(1, rv); check("R2 high nibble", rv, 8'h0B);
    wr(4, 8'h5C); rd(4, rv); check("R2 low byte", rv, 8'h5C);

    // sweep all divide ratios over several settings
    for (int p = 0; p < 8; p++) begin
      run_pwm(p, 3, 5, 9, 2, p % 2, 0, 0, 0);
      run_pwm(p, 1, 0, 4, 0, 1, 0, 0, 0);
      run_pwm(p, 4, 7, 12, 4, (p + 1) % 2, 0, 0, 0);
      run_pwm(p, 2, 3, 6, 2, 1, 0, 0, 0);
    end
    run_pwm(0, 12'h100, 12'h110, 12'h120, 31, 1, 0, 0, 0);
    run_pwm(1, 4, 7, 12, 2, 1, 1, 3, 2);
    run_pwm(0, 5, 1, 10, 1, 1, 1, 2, 8);

    // capture mode
    @(negedge clk);
    cap_mode = 1'b1; cap_fall = 1'b0; psel = 3'd0; adc_en = 1'b0; cap_in = 1'b0;
    set12(0, 5);
    wr(7, 1);
    enable = 1'b1;
    repeat (20) @(negedge clk);
    check("R11 hs2_oe in capture", int'(hs2_oe), 0);
    check("R11 hs2 low in capture", int'(hs2_o), 0);
    check("R13 hs1 high past compare A", int'(hs1_o), 1);
    capture_pulse(1'b1, ex, got);
    check("R11 rising capture value", got, ex);
    rd(7, rv); check("R11 flag set", rv, 1);
    wr(7, 0); rd(7, rv); check("R12 write 0 keeps flag", rv, 1);
    wr(7, 1); rd(7, rv); check("R12 write 1 clears flag", rv, 0);
    repeat (37) @(negedge clk);
    cap_fall = 1'b1;
    @(negedge clk);
    capture_pulse(1'b0, ex, got);
    check("R11 falling capture value", got, ex);
    rd(7, rv); check("R11 flag after falling edge", rv, 1);
    wr(7, 1);
    rd(4, ex);
    cap_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(4, rv); check("R11 wrong edge ignored value", rv, ex);
    rd(7, rv); check("R11 wrong edge ignored flag", rv, 0);
    // R13 free run through full range
    begin
      int guard = 0;
      while (count_o != 12'hFFF && guard < 5000) begin
        @(negedge clk); guard++;
      end
      check("R13 reaches 0xFFF", int'(count_o), 12'hFFF);
      check("R13 hs1 high before wrap", int'(hs1_o), 1);
      @(negedge clk);
      check("R13 wraps to 0", int'(count_o), 0);
      check("R13 hs1 low after wrap", int'(hs1_o), 0);
    end
    enable = 1'b0;
    @(negedge clk);
    check("R10 count cleared", int'(count_o), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule